// File: doc/BRIEF.md
# Keyboard Character Input Port

This block is a bus-addressed peripheral that receives characters from a keyboard-side source and hands them to a processor. Each time the source pulses its strobe, the block captures the character into a holding register and raises a ready indication. Software finds this indication either by polling a status byte or by taking an interrupt. Polling software loads the status byte, tests the ready bit and then loads the character. Interrupt-driven software first sets an enable bit in the control byte. It then waits for the request line, and the processor's acknowledge pulse withdraws that request.

All three registers are byte wide and sit at small fixed offsets. Reads are combinational and return the register contents in the same cycle. Loading the status byte has a side effect at the end of that cycle: it consumes the ready and overrun indications. Loading the character byte has no side effect.

Top module: `kbd_input_port`

## Requirements
- R1: A synchronous active-high reset clears the character register, the ready bit, the overrun bit, the interrupt enable and the pending request. After reset, every offset reads 0 and `irq` is low.
- R2: A cycle with `char_valid` high stores `char_data`. From the next cycle, offset 0 returns that character and offset 1 has bit 1 (mask 0x02, the ready bit) set.
- R3: A read of offset 1 in a cycle without `char_valid` clears the ready bit and the overrun bit from the next cycle. A read of offset 0 leaves both bits unchanged.
- R4: A character that arrives while the ready bit is set replaces the stored character and sets status bit 3 (mask 0x08, overrun). If a read of offset 1 happens in the same cycle as the arrival, the result is ready set and overrun clear.
- R5: Offset 2 is the control byte. A write stores `bus_wdata[1]` as the interrupt enable, and a read returns that bit at position 1 with all other bits 0. Writes to offsets 0, 1 and 3 change nothing.
- R6: `irq` is high only while the ready bit is set, the interrupt enable is 1 and the request has not been acknowledged. With the enable at 0, `irq` stays low even when a character is waiting.
- R7: `irq_ack` drops `irq` from the next cycle, and `irq` stays low until a new character arrives. A character that arrives in the same cycle as `irq_ack` re-arms the request.
- R8: Reads of offset 3 return 0, and `bus_rdata` is 0 in any cycle where `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | One-cycle strobe from the source: a new character is present |
| char_data | input | 8 | Character from the source |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Byte load this cycle |
| bus_wr | input | 1 | Byte store this cycle |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Load data, combinational |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| irq | output | 1 | Interrupt request |

## Verification
A wrong internal bit shows up at the ports no later than the next load of the affected offset. A ready or overrun bit that is stuck or cleared at the wrong time appears in the status byte. A lost or stale character appears in the data byte. The request line is a direct function of the ready bit, the enable and the acknowledge state, so an error in any of these shows on `irq` in the cycle after the edge that caused it. The bench therefore compares `irq` on every cycle and `bus_rdata` on every load against a reference model. It mixes random traffic with the same-cycle collisions: arrival with status load, and arrival with acknowledge.

// File: rtl/kbd_input_port.sv
module kbd_input_port #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int OFF_DATA = 0,
  parameter int OFF_STAT = 1,
  parameter int OFF_CTRL = 2,
  parameter int RDY_BIT  = 1,
  parameter int OVR_BIT  = 3,
  parameter int IE_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic [DATA_W-1:0] char_q;
  logic rdy_q, ovr_q, ie_q, armed_q;
  logic [DATA_W-1:0] stat_word, ctrl_word;

  wire stat_rd = bus_rd && (bus_addr == A_STAT);
  wire ctrl_wr = bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      char_q  <= '0;
      rdy_q   <= 1'b0;
      ovr_q   <= 1'b0;
      ie_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (char_valid) begin
        char_q  <= char_data;
        rdy_q   <= 1'b1;
        armed_q <= 1'b1;
        if (stat_rd)    ovr_q <= 1'b0;
        else if (rdy_q) ovr_q <= 1'b1;
      end else begin
        if (stat_rd) begin
          rdy_q <= 1'b0;
          ovr_q <= 1'b0;
        end
        if (irq_ack) armed_q <= 1'b0;
      end
      if (ctrl_wr) ie_q <= bus_wdata[IE_BIT];
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[RDY_BIT] = rdy_q;
    stat_word[OVR_BIT] = ovr_q;
    ctrl_word = '0;
    ctrl_word[IE_BIT] = ie_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_DATA:  bus_rdata = char_q;
        A_STAT:  bus_rdata = stat_word;
        A_CTRL:  bus_rdata = ctrl_word;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = armed_q & rdy_q & ie_q;

  // R2: a strobe makes the ready bit visible in the next cycle
  a_r2_ready_set: assert property (@(posedge clk) disable iff (rst)
    char_valid |=> rdy_q);

  // R3: a status load without an arrival consumes both flags
  a_r3_status_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !char_valid) |=> (!rdy_q && !ovr_q));

  // R4: an arrival on top of a waiting character flags overrun
  a_r4_overrun: assert property (@(posedge clk) disable iff (rst)
    (char_valid && rdy_q && !stat_rd) |=> ovr_q);

  // R5: a control store sets the enable from bit IE_BIT
  a_r5_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (ie_q == $past(bus_wdata[IE_BIT])));

  // R6: with the enable low and no control store, no request follows
  a_r6_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (!ie_q && !ctrl_wr) |=> !irq);

  // R7: acknowledge without a new arrival withdraws the request
  a_r7_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !char_valid) |=> !irq);

endmodule

// File: tb/tb_kbd_input_port.sv
`timescale 1ns/1ps
module tb_kbd_input_port;
  logic clk = 1'b0;
  logic rst;
  logic char_valid, bus_rd, bus_wr, irq_ack, irq;
  logic [7:0] char_data, bus_wdata, bus_rdata;
  logic [1:0] bus_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_data;
  bit m_rdy, m_ovr, m_ie, m_armed;

  always #10 clk = ~clk;

  kbd_input_port dut (
    .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq(irq)
  );

  function automatic logic [7:0] exp_rdata(bit rd, logic [1:0] a);
    if (!rd) return 8'h00;
    case (a)
      2'd0: return m_data;
      2'd1: return {4'b0, m_ovr, 1'b0, m_rdy, 1'b0};
      2'd2: return {6'b0, m_ie, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit exp_irq();
    return m_armed && m_rdy && m_ie;
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic cycle(string tag, bit v, logic [7:0] ch, bit rd, bit wr,
                       logic [1:0] a, logic [7:0] wd, bit ack);
    bit rs;
    @(negedge clk);
    char_valid = v; char_data = ch; bus_rd = rd; bus_wr = wr;
    bus_addr = a; bus_wdata = wd; irq_ack = ack;
    #1;
    check8(tag, bus_rdata, exp_rdata(rd, a));
    check8((tag == "R1") ? "R1" : (m_ie ? "R7" : "R6"), {7'b0, irq}, {7'b0, exp_irq()});
    @(posedge clk);
    rs = rd && (a == 2'd1);
    if (v) begin
      m_data = ch; m_armed = 1'b1;
      if (rs) m_ovr = 1'b0; else if (m_rdy) m_ovr = 1'b1;
      m_rdy = 1'b1;
    end else begin
      if (rs) begin m_rdy = 1'b0; m_ovr = 1'b0; end
      if (ack) m_armed = 1'b0;
    end
    if (wr && a == 2'd2) m_ie = wd[1];
  endtask

  function automatic string tag_for(bit rd, logic [1:0] a);
    if (!rd) return "R8";
    case (a)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R5";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst = 1'b1; char_valid = 0; char_data = 0; bus_rd = 0; bus_wr = 0;
    bus_addr = 0; bus_wdata = 0; irq_ack = 0;
    m_data = 0; m_rdy = 0; m_ovr = 0; m_ie = 0; m_armed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state on every offset
    for (int i = 0; i < 4; i++) cycle("R1", 0, 0, 1, 0, 2'(i), 0, 0);

    // R2: capture and ready bit; R3: data load keeps ready
    cycle("R2", 1, 8'h41, 0, 0, 0, 0, 0);
    cycle("R2", 0, 0, 1, 0, 2'd0, 0, 0);
    cycle("R3", 0, 0, 1, 0, 2'd1, 0, 0);
    cycle("R3", 0, 0, 1, 0, 2'd1, 0, 0);

    // R4: overrun, then cleared by status load
    cycle("R4", 1, 8'h10, 0, 0, 0, 0, 0);
    cycle("R4", 1, 8'h20, 0, 0, 0, 0, 0);
    cycle("R4", 0, 0, 1, 0, 2'd0, 0, 0);
    cycle("R4", 0, 0, 1, 0, 2'd1, 0, 0);
    cycle("R4", 0, 0, 1, 0, 2'd1, 0, 0);
    // R4: arrival in the same cycle as a status load
    cycle("R4", 1, 8'h31, 0, 0, 0, 0, 0);
    cycle("R4", 1, 8'h32, 1, 0, 2'd1, 0, 0);
    cycle("R4", 0, 0, 1, 0, 2'd1, 0, 0);

    // R5: ignored stores, then control read/write
    cycle("R5", 0, 0, 0, 1, 2'd0, 8'hFF, 0);
    cycle("R5", 0, 0, 0, 1, 2'd1, 8'hFF, 0);
    cycle("R5", 0, 0, 0, 1, 2'd3, 8'hFF, 0);
    cycle("R5", 0, 0, 1, 0, 2'd0, 0, 0);
    cycle("R5", 0, 0, 1, 0, 2'd2, 0, 0);
    cycle("R5", 0, 0, 0, 1, 2'd2, 8'hFD, 0);
    cycle("R5", 0, 0, 1, 0, 2'd2, 0, 0);

    // R6: enable off while a character waits, then on
    cycle("R6", 1, 8'h55, 0, 0, 0, 0, 0);
    cycle("R6", 0, 0, 0, 0, 0, 0, 0);
    cycle("R6", 0, 0, 0, 1, 2'd2, 8'h02, 0);
    cycle("R6", 0, 0, 0, 0, 0, 0, 0);

    // R7: acknowledge, and acknowledge colliding with an arrival
    cycle("R7", 0, 0, 0, 0, 0, 0, 1);
    cycle("R7", 0, 0, 0, 0, 0, 0, 0);
    cycle("R7", 1, 8'h66, 0, 0, 0, 0, 1);
    cycle("R7", 0, 0, 0, 0, 0, 0, 0);

    // R8: unmapped offset with data waiting
    cycle("R8", 0, 0, 1, 0, 2'd3, 0, 0);

    for (int k = 0; k < 3000; k++) begin
      bit v, rd, wr, ack;
      logic [1:0] a;
      v   = ($urandom_range(0, 9) < 3);
      rd  = ($urandom_range(0, 1) == 1);
      wr  = !rd && ($urandom_range(0, 4) == 0);
      ack = ($urandom_range(0, 4) == 0);
      a   = 2'($urandom_range(0, 3));
      cycle(tag_for(rd, a), v, 8'($urandom), rd, wr, a, 8'($urandom), ack);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule